// File: doc/BRIEF.md
# Floating-Point Register Stack with Value Tags

This block holds eight floating-point registers that software addresses by their distance from a rotating top-of-stack pointer rather than by fixed physical location. Name ST(i) always resolves to physical slot (top + i) mod 8. A push places a value in the slot just above the current top and makes it the new ST(0), so every earlier entry gains one in its name. An operation cycle may write any ST(i), then remove zero, one or two entries from the top.

Each physical slot carries a two-bit class tag. Whenever a value enters a slot, the tag is worked out from that value's exponent and fraction. A pop marks a slot empty. The empty tag drives fault detection. A push onto an occupied slot is an overflow. A read or pop of an empty slot is an underflow. Either fault leaves the stack untouched and raises the C1 condition flag and a one-cycle fault pulse. Arithmetic, format conversion and exception handling live in neighbouring blocks.

Top module: `fp_tag_stack`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears top_ptr to 0, sets every tag to 11 (empty), and clears c1 and fault.
- R2: A value written into a slot gets its tag from the value. Exponent field all ones gives 10. Exponent zero with a nonzero fraction gives 10. Exponent zero with a zero fraction gives 01. Any other value gives 00. The tag for physical slot k appears at tag_word bits [2k+1:2k].
- R3: An accepted push decrements top_ptr mod 8 and stores push_value and its tag in the new top slot. The entry formerly at ST(i) is then found at ST(i+1).
- R4: In a cycle without push, pop_cnt = 1 marks ST(0) empty and adds 1 to top_ptr. pop_cnt = 2 or 3 marks ST(0) and ST(1) empty and adds 2 to top_ptr.
- R5: A push whose target slot is not tagged empty is an overflow. It changes neither top_ptr nor any slot, and it sets c1 and fault.
- R6: Underflow covers three cases: rd_en with ST(rd_idx) empty, a pop with ST(0) empty, and a double pop with ST(1) empty. On underflow the whole cycle (write and pops) is dropped, and c1 and fault are set.
- R7: wr_en with pop_cnt = 0 replaces ST(wr_idx) with wr_value and its tag and leaves top_ptr unchanged.
- R8: When wr_en and a pop share a cycle, wr_idx names a slot relative to the old top, and the write lands before the pops. The written value therefore appears at ST(wr_idx - pops). A slot that the pop removes ends up empty.
- R9: When push_en is high, wr_en, rd_en and pop_cnt are ignored, and only the push can fault.
- R10: c1 takes the fault outcome of every cycle in which any of push_en, rd_en, wr_en or a nonzero pop_cnt is high, and holds its value in idle cycles. fault is high only in the cycle after a faulting operation.
- R11: rd_value and rd_tag show, combinationally, the value and tag of ST(rd_idx) for the current top_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_en | input | 1 | Push push_value as new ST(0) |
| push_value | input | 32 | Value to push |
| rd_en | input | 1 | Read ST(rd_idx) is consumed (checks for underflow) |
| rd_idx | input | 3 | Stack index of the read port |
| rd_value | output | 32 | Value held at ST(rd_idx) |
| rd_tag | output | 2 | Tag of ST(rd_idx) |
| wr_en | input | 1 | Write wr_value into ST(wr_idx) |
| wr_idx | input | 3 | Stack index of the write, relative to the pre-pop top |
| wr_value | input | 32 | Value to write |
| pop_cnt | input | 2 | Entries to remove after the write: 0, 1, 2 (3 acts as 2) |
| top_ptr | output | 3 | Physical slot that is ST(0) |
| tag_word | output | 16 | Tags of all physical slots, slot k at bits [2k+1:2k] |
| c1 | output | 1 | Stack fault outcome of the last active cycle |
| fault | output | 1 | One-cycle pulse after an overflow or underflow |

## Verification
Two pairs of functions can fall in one cycle. A write can share a cycle with a pop, and a push can share a cycle with the write, read and pop inputs that it overrides. The bench drives a write to ST(2) together with one pop and expects the value to come back at ST(1). It drives a write to ST(0) together with one pop and expects that slot to end empty. It also asserts push_en together with a double pop and a read of an empty index, and expects only the push to take effect, with no fault. A behavioural model built on plain arrays and integers predicts top_ptr, every tag, the read port, c1 and fault. These are compared after every clock edge, and the model also covers the fault cases in which a write paired with a bad pop must vanish.

// File: rtl/fp_tag_stack_pkg.sv
// Shared types for the floating-point register stack.
// Assumes: the tag code points are fixed by neighbouring decode logic.
package fp_tag_stack_pkg;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

endpackage

// File: rtl/fp_tag_classify.sv
// Classifies a floating-point value into a stack tag.
// Assumes: value = {sign, exponent[EXP_W], fraction[FRAC_W]}.
module fp_tag_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0]        value,
    output fp_tag_stack_pkg::tag_e   tag
);
    import fp_tag_stack_pkg::*;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = value[FRAC_W +: EXP_W];
    assign frac_f = value[FRAC_W-1:0];

    // Purpose: map exponent/fraction patterns onto the tag code.
    always_comb begin
        if (&exp_f)
            tag = TAG_SPECIAL;
        else if (exp_f == '0)
            tag = (frac_f == '0) ? TAG_ZERO : TAG_SPECIAL;
        else
            tag = TAG_VALID;
    end
endmodule

// File: rtl/fp_tag_ctrl.sv
// Decision logic: resolves stack names to physical slots, detects
// overflow/underflow and decides which updates are allowed this cycle.
// Assumes: DEPTH is a power of two so pointer arithmetic wraps naturally.
module fp_tag_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [2*DEPTH-1:0] tag_word,
    input  logic [PTR_W-1:0]   top,
    input  logic               push_en,
    input  logic               rd_en,
    input  logic [PTR_W-1:0]   rd_idx,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_idx,
    input  logic [1:0]         pop_cnt,
    output logic [PTR_W-1:0]   push_slot,
    output logic [PTR_W-1:0]   rd_slot,
    output logic [PTR_W-1:0]   wr_slot,
    output logic [PTR_W-1:0]   st0_slot,
    output logic [PTR_W-1:0]   st1_slot,
    output logic               do_push,
    output logic               do_write,
    output logic               do_pop1,
    output logic               do_pop2,
    output logic               fault_now,
    output logic               active
);
    import fp_tag_stack_pkg::*;

    logic want_pop1, want_pop2, overflow, underflow;

    function automatic logic slot_empty(input logic [2*DEPTH-1:0] tw,
                                        input logic [PTR_W-1:0] s);
        return tw[int'(s)*2 +: 2] == TAG_EMPTY;
    endfunction

    // Purpose: translate stack-relative names into physical slots.
    always_comb begin
        push_slot = top - PTR_W'(1);
        rd_slot   = top + rd_idx;
        wr_slot   = top + wr_idx;
        st0_slot  = top;
        st1_slot  = top + PTR_W'(1);
    end

    // Purpose: fault detection and gating of every state update.
    always_comb begin
        want_pop1 = (pop_cnt != 2'd0);
        want_pop2 = pop_cnt[1];
        overflow  = push_en && !slot_empty(tag_word, push_slot);
        underflow = !push_en &&
                    ((rd_en     && slot_empty(tag_word, rd_slot))  ||
                     (want_pop1 && slot_empty(tag_word, st0_slot)) ||
                     (want_pop2 && slot_empty(tag_word, st1_slot)));
        fault_now = overflow || underflow;
        do_push   = push_en && !overflow;
        do_write  = !push_en && wr_en && !underflow;
        do_pop1   = !push_en && want_pop1 && !underflow;
        do_pop2   = !push_en && want_pop2 && !underflow;
        active    = push_en || rd_en || wr_en || want_pop1;
    end
endmodule

// File: rtl/fp_tag_regs.sv
// Physical register file with one tag per slot. Tags are computed from
// the incoming value; pops override writes to the same slot.
// Assumes: do_push excludes do_write/do_pop* (guaranteed by fp_tag_ctrl).
module fp_tag_regs #(
    parameter int DEPTH  = 8,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DATA_W = 1 + EXP_W + FRAC_W,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_push,
    input  logic [PTR_W-1:0]   push_slot,
    input  logic [DATA_W-1:0]  push_value,
    input  logic               do_write,
    input  logic [PTR_W-1:0]   wr_slot,
    input  logic [DATA_W-1:0]  wr_value,
    input  logic               do_pop1,
    input  logic [PTR_W-1:0]   st0_slot,
    input  logic               do_pop2,
    input  logic [PTR_W-1:0]   st1_slot,
    input  logic [PTR_W-1:0]   rd_slot,
    output logic [DATA_W-1:0]  rd_value,
    output logic [1:0]         rd_tag,
    output logic [2*DEPTH-1:0] tag_word
);
    import fp_tag_stack_pkg::*;

    logic [DATA_W-1:0] mem  [DEPTH];
    tag_e              tags [DEPTH];
    tag_e              push_tag, wr_tag;

    fp_tag_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_push (
        .value (push_value),
        .tag   (push_tag)
    );

    fp_tag_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_wr (
        .value (wr_value),
        .tag   (wr_tag)
    );

    // Purpose: value storage; no reset, emptiness is tracked by tags.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (do_push && push_slot == PTR_W'(k))
                mem[k] <= push_value;
            else if (do_write && wr_slot == PTR_W'(k))
                mem[k] <= wr_value;
        end
    end

    // Purpose: tag update; pops win over a same-cycle write to the slot.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n)
                tags[k] <= TAG_EMPTY;
            else if (do_pop1 && st0_slot == PTR_W'(k))
                tags[k] <= TAG_EMPTY;
            else if (do_pop2 && st1_slot == PTR_W'(k))
                tags[k] <= TAG_EMPTY;
            else if (do_push && push_slot == PTR_W'(k))
                tags[k] <= push_tag;
            else if (do_write && wr_slot == PTR_W'(k))
                tags[k] <= wr_tag;
        end
    end

    // Purpose: pack per-slot tags into the flat tag word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_pack
        assign tag_word[2*g +: 2] = tags[g];
    end

    // Purpose: combinational read port.
    assign rd_value = mem[rd_slot];
    assign rd_tag   = tags[rd_slot];
endmodule

// File: rtl/fp_tag_stack.sv
// Top of the floating-point register stack: owns the top pointer and
// the condition flag, and joins the decision logic to the register file.
// Assumes: one operation per cycle; DEPTH a power of two >= 2.
module fp_tag_stack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int DEPTH  = 8,
    localparam int DATA_W = 1 + EXP_W + FRAC_W,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_en,
    input  logic [DATA_W-1:0]  push_value,
    input  logic               rd_en,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_value,
    output logic [1:0]         rd_tag,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_value,
    input  logic [1:0]         pop_cnt,
    output logic [PTR_W-1:0]   top_ptr,
    output logic [2*DEPTH-1:0] tag_word,
    output logic               c1,
    output logic               fault
);
    logic [PTR_W-1:0] push_slot, rd_slot, wr_slot, st0_slot, st1_slot;
    logic do_push, do_write, do_pop1, do_pop2, fault_now, active;

    fp_tag_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .tag_word  (tag_word),
        .top       (top_ptr),
        .push_en   (push_en),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .pop_cnt   (pop_cnt),
        .push_slot (push_slot),
        .rd_slot   (rd_slot),
        .wr_slot   (wr_slot),
        .st0_slot  (st0_slot),
        .st1_slot  (st1_slot),
        .do_push   (do_push),
        .do_write  (do_write),
        .do_pop1   (do_pop1),
        .do_pop2   (do_pop2),
        .fault_now (fault_now),
        .active    (active)
    );

    fp_tag_regs #(.DEPTH(DEPTH), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_push    (do_push),
        .push_slot  (push_slot),
        .push_value (push_value),
        .do_write   (do_write),
        .wr_slot    (wr_slot),
        .wr_value   (wr_value),
        .do_pop1    (do_pop1),
        .st0_slot   (st0_slot),
        .do_pop2    (do_pop2),
        .st1_slot   (st1_slot),
        .rd_slot    (rd_slot),
        .rd_value   (rd_value),
        .rd_tag     (rd_tag),
        .tag_word   (tag_word)
    );

    // Purpose: move the top pointer on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            top_ptr <= '0;
        else if (do_push)
            top_ptr <= top_ptr - PTR_W'(1);
        else if (do_pop2)
            top_ptr <= top_ptr + PTR_W'(2);
        else if (do_pop1)
            top_ptr <= top_ptr + PTR_W'(1);
    end

    // Purpose: condition flag and fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1    <= 1'b0;
            fault <= 1'b0;
        end else begin
            fault <= fault_now;
            if (active)
                c1 <= fault_now;
        end
    end
endmodule

// File: rtl/fp_tag_stack_chk.sv
// Property checker for fp_tag_stack, attached by bind.
// Assumes: rst_n is low from time zero until the first edges.
module fp_tag_stack_chk #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               push_en,
    input logic [1:0]         pop_cnt,
    input logic [PTR_W-1:0]   top_ptr,
    input logic [2*DEPTH-1:0] tag_word,
    input logic               c1,
    input logic               fault
);
    function automatic logic [1:0] slot_tag(input logic [2*DEPTH-1:0] tw,
                                            input logic [PTR_W-1:0] s);
        return tw[int'(s)*2 +: 2];
    endfunction

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (top_ptr == '0 && &tag_word && !c1 && !fault)); // R1

    AST_PUSH_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (fault || (top_ptr + PTR_W'(1)) == $past(top_ptr))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && slot_tag(tag_word, top_ptr - PTR_W'(1)) != 2'b11)
        |=> (fault && c1 && $stable(top_ptr) && $stable(tag_word))); // R5

    AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && pop_cnt == 2'd1)
        |=> (fault || (top_ptr == $past(top_ptr) + PTR_W'(1) &&
                       slot_tag(tag_word, $past(top_ptr)) == 2'b11))); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && pop_cnt != 2'd0 && slot_tag(tag_word, top_ptr) == 2'b11)
        |=> (fault && $stable(top_ptr) && $stable(tag_word))); // R6

    AST_FAULT_SETS_C1: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> c1); // R10
endmodule

bind fp_tag_stack fp_tag_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (push_en),
    .pop_cnt  (pop_cnt),
    .top_ptr  (top_ptr),
    .tag_word (tag_word),
    .c1       (c1),
    .fault    (fault)
);

// File: tb/fp_tag_stack_test.sv
`timescale 1ns/1ps
module fp_tag_stack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] push_value = '0, wr_value = '0;
    logic [2:0]  rd_idx = '0, wr_idx = '0;
    logic [1:0]  pop_cnt = '0;
    logic [31:0] rd_value;
    logic [1:0]  rd_tag;
    logic [2:0]  top_ptr;
    logic [15:0] tag_word;
    logic        c1, fault;

    int checks = 0, errors = 0;
    logic [31:0] mval [8];
    int          mtag [8];
    int          mtop, mc1, mfault;

    always #2 clk = ~clk;

    fp_tag_stack uut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_value(push_value),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_value(rd_value), .rd_tag(rd_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value), .pop_cnt(pop_cnt),
        .top_ptr(top_ptr), .tag_word(tag_word), .c1(c1), .fault(fault)
    );

    function automatic int classify(input logic [31:0] v);
        int e = int'(v[30:23]);
        int f = int'(v[22:0]);
        if (e == 255) return 2;
        if (e == 0) return (f == 0) ? 1 : 2;
        return 0;
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_state(input string req);
        logic [15:0] tw = '0;
        for (int k = 0; k < 8; k++) tw[2*k +: 2] = 2'(mtag[k]);
        check(req, "top_ptr", top_ptr, mtop);
        check(req, "tag_word", tag_word, tw);
        check(req, "c1", c1, mc1);
        check(req, "fault", fault, mfault);
    endtask

    // One operation cycle: drive, check read port, advance model, compare.
    task automatic step(input bit pe, input logic [31:0] pv, input bit re,
                        input int ri, input bit we, input int wi,
                        input logic [31:0] wv, input int pc, input string req);
        int  rs, np;
        bit  ovf, und, act;
        @(negedge clk);
        push_en = pe; push_value = pv; rd_en = re; rd_idx = 3'(ri);
        wr_en = we; wr_idx = 3'(wi); wr_value = wv; pop_cnt = 2'(pc);
        #1;
        rs = (mtop + ri) % 8;
        check("R11", "rd_tag", rd_tag, mtag[rs]);
        if (mtag[rs] != 3) check("R11", "rd_value", rd_value, mval[rs]);
        np  = (pc >= 2) ? 2 : pc;
        ovf = pe && mtag[(mtop + 7) % 8] != 3;
        und = !pe && ((re && mtag[rs] == 3) || (np >= 1 && mtag[mtop] == 3) ||
                      (np >= 2 && mtag[(mtop + 1) % 8] == 3));
        act = pe || re || we || (pc != 0);
        if (pe) begin
            if (!ovf) begin
                mtop = (mtop + 7) % 8;
                mval[mtop] = pv;
                mtag[mtop] = classify(pv);
            end
        end else if (!und) begin
            if (we) begin
                mval[(mtop + wi) % 8] = wv;
                mtag[(mtop + wi) % 8] = classify(wv);
            end
            if (np >= 1) mtag[mtop] = 3;
            if (np >= 2) mtag[(mtop + 1) % 8] = 3;
            mtop = (mtop + np) % 8;
        end
        mfault = (ovf || und) ? 1 : 0;
        if (act) mc1 = mfault;
        @(posedge clk);
        #1;
        compare_state(req);
    endtask

    task automatic do_push(input logic [31:0] v, input string req);
        step(1, v, 0, 0, 0, 0, 32'h0, 0, req);
    endtask

    task automatic do_idle(input string req);
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 0, req);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin mtag[k] = 3; mval[k] = '0; end
        mtop = 0; mc1 = 0; mfault = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_state("R1");                      // R1 reset state
        do_idle("R1");

        // R3/R2: fill all eight slots with each tag class, wrapping top.
        do_push(32'h3F800000, "R3");              // normal -> 00
        do_push(32'h00000000, "R2");              // +0 -> 01
        do_push(32'h7F800000, "R2");              // inf -> 10
        do_push(32'h00000001, "R2");              // denormal -> 10
        do_push(32'h7FC00000, "R2");              // NaN -> 10
        do_push(32'hC0000000, "R3");              // normal negative -> 00
        do_push(32'h80000000, "R2");              // -0 -> 01
        do_push(32'h40490FDB, "R3");              // last slot, top back to 0

        // R11: read every name of the full stack.
        for (int i = 0; i < 8; i++) step(0, 32'h0, 1, i, 0, 0, 32'h0, 0, "R11");

        do_push(32'h41200000, "R5");              // R5 overflow on full stack
        do_idle("R10");                           // R10 c1 held while idle

        step(0, 32'h0, 0, 0, 1, 3, 32'h007FFFFF, 0, "R7"); // R7 write ST3
        step(0, 32'h0, 0, 0, 1, 2, 32'h3F000000, 1, "R8"); // R8 write then pop
        step(0, 32'h0, 1, 1, 0, 0, 32'h0, 0, "R8");        // see it at ST1
        step(0, 32'h0, 0, 0, 1, 0, 32'h3F000000, 1, "R8"); // R8 popped slot empty
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 2, "R4");        // R4 double pop
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 3, "R4");        // R4 code 3 acts as 2

        // R9: push overrides a double pop, a write and a read of an empty name.
        step(1, 32'h40000000, 1, 5, 1, 1, 32'h0, 2, "R9");
        step(0, 32'h0, 1, 0, 0, 0, 32'h0, 0, "R9");
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 1, "R4");
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 2, "R4");        // stack now empty

        // R6 underflow variants.
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 1, "R6");        // pop of empty
        step(0, 32'h0, 1, 0, 0, 0, 32'h0, 0, "R6");        // read of empty
        step(0, 32'h0, 0, 0, 1, 0, 32'h3F800000, 1, "R6"); // write dropped
        do_push(32'h3F800000, "R3");
        step(0, 32'h0, 0, 0, 1, 0, 32'h0, 2, "R6");        // ST1 empty on double pop
        do_idle("R10");
        step(0, 32'h0, 1, 0, 0, 0, 32'h0, 0, "R10");       // clean read clears c1
        step(0, 32'h0, 0, 0, 1, 0, 32'hFF800000, 0, "R2"); // -inf -> 10
        step(0, 32'h0, 0, 0, 0, 0, 32'h0, 1, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule